// File: doc/BRIEF.md
# Polarity-Selectable 10-bit Pulse-Width Modulator

The block turns a prescaled tick into a pulse train whose period and active time are each set to 10-bit precision. Software writes the low eight bits of the period and of the active length (the "duty") into two byte registers. The two upper bits of each value go together into one shared high register. A control register holds an enable bit and a polarity bit. The polarity bit sets the level that is driven during the duty part of the cycle.

A counter steps once per tick from zero up to the period value and then wraps. Values written by software go into staging registers. They are copied into the working copies only at a wrap, or at any time while the block is disabled, so a reprogram never cuts a pulse short. When the duty equals the period, the output stays constant at the duty level. While the block is disabled, the output rests at the level opposite to the polarity bit.

Top module: `pwm10_polsel`

## Requirements
- R1: After reset, enable and polarity are 0, all period and duty bits are 0, and `pwmOut` is 1 (the idle level for polarity 0).
- R2: A write with `wrSel`=2 sets the period's upper two bits from `wrData[3:2]` and the duty's upper two bits from `wrData[1:0]`; `wrData[7:4]` has no effect. `wrSel`=0 writes the period low byte, `wrSel`=1 the duty low byte, and `wrSel`=3 the control register with bit 0 = enable and bit 1 = polarity.
- R3: While enabled, the count advances by one on each cycle with `tick` high, from 0 up to the working period P, then returns to 0. A cycle of the waveform therefore lasts P+1 ticks.
- R4: While enabled with duty D below P, `pwmOut` is at the duty level when the count is below D and at the opposite level otherwise. With D=0 the output never reaches the duty level.
- R5: The duty level is 1 when polarity is 1 and 0 when polarity is 0.
- R6: While enabled with D equal to P, `pwmOut` stays at the duty level on every count. A D greater than P gives the same result.
- R7: While enabled, new period and duty values take effect only at the tick that wraps the count from P to 0. Until then the old values keep shaping the output.
- R8: While disabled, `pwmOut` equals the inverse of polarity and the count is held at 0. Enabling starts the count at 0 with the most recently written values.
- R9: The count holds its value on cycles with `tick` low, including cycles with register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 period low, 1 duty low, 2 shared high, 3 control |
| wrData | input | 8 | Write data |
| tick | input | 1 | Prescaled count enable |
| pwmOut | output | 1 | Waveform output |

## Verification
The bench sweeps periods from 0 to the full 1023, using duties of zero, one, half the period, equal to the period and one beyond it, under both polarities. This catches a design that glitches for one count at the top when duty equals period, or that lets a zero period stall. It reprograms in mid-cycle and checks that the old pulse completes: a design that loaded at once would shorten or stretch the current pulse. It also checks that the upper nibble of the shared high register is dropped. Gapped ticks and idle-level checks expose a counter that runs without a tick or an output that ignores polarity while disabled.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  typedef struct packed {
    logic inc;   // advance count
    logic clr;   // return count to zero
    logic load;  // copy staged values to working copies
    logic run;   // block enabled
    logic pol;   // duty level
  } pwmStrobe_t;

  typedef enum logic [1:0] {
    SEL_PER_LO  = 2'd0,
    SEL_DUTY_LO = 2'd1,
    SEL_HIGH    = 2'd2,
    SEL_CTRL    = 2'd3
  } regSel_t;
endpackage

// File: rtl/pwm10_ctrl.sv
module pwm10_ctrl
  import pwm10_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int LOW_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          wrSel,
  input  logic [LOW_BITS-1:0] wrData,
  input  logic                tick,
  input  logic                atTop,
  output pwmStrobe_t          strb,
  output logic [RES_BITS-1:0] perStg,
  output logic [RES_BITS-1:0] dutyStg
);
  localparam int HIGH_BITS = RES_BITS - LOW_BITS;

  logic [LOW_BITS-1:0]  perLo, dutyLo;
  logic [HIGH_BITS-1:0] perHi, dutyHi;
  logic                 enReg, polReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perLo  <= '0;
      dutyLo <= '0;
      perHi  <= '0;
      dutyHi <= '0;
      enReg  <= 1'b0;
      polReg <= 1'b0;
    end else if (wrEn) begin
      case (regSel_t'(wrSel))
        SEL_PER_LO:  perLo  <= wrData;
        SEL_DUTY_LO: dutyLo <= wrData;
        SEL_HIGH: begin
          perHi  <= wrData[2*HIGH_BITS-1:HIGH_BITS];
          dutyHi <= wrData[HIGH_BITS-1:0];
        end
        default: begin
          enReg  <= wrData[0];
          polReg <= wrData[1];
        end
      endcase
    end
  end

  assign perStg  = {perHi, perLo};
  assign dutyStg = {dutyHi, dutyLo};

  logic wrapNow;
  assign wrapNow = enReg && tick && atTop;

  always_comb begin
    strb.run  = enReg;
    strb.pol  = polReg;
    strb.inc  = enReg && tick && !atTop;
    strb.clr  = !enReg || wrapNow;
    strb.load = !enReg || wrapNow;
  end

  // R9: without a tick an enabled block must not move its count
  p_no_step_without_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enReg && !tick) |-> (!strb.inc && !strb.clr));
endmodule

// File: rtl/pwm10_datapath.sv
module pwm10_datapath
  import pwm10_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  pwmStrobe_t          strb,
  input  logic [RES_BITS-1:0] perStg,
  input  logic [RES_BITS-1:0] dutyStg,
  output logic                atTop,
  output logic                pwmOut
);
  logic [RES_BITS-1:0] cnt, perAct, dutyAct;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      perAct  <= '0;
      dutyAct <= '0;
    end else begin
      if (strb.load) begin
        perAct  <= perStg;
        dutyAct <= dutyStg;
      end
      if (strb.clr)      cnt <= '0;
      else if (strb.inc) cnt <= cnt + 1'b1;
    end
  end

  assign atTop = (cnt == perAct);

  logic fullDuty, inDuty;
  always_comb begin
    fullDuty = (dutyAct >= perAct);
    inDuty   = fullDuty || (cnt < dutyAct);
    pwmOut   = (strb.run && inDuty) ? strb.pol : !strb.pol;
  end

  // R3: count never passes the working period
  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= perAct);
  // R7: working values only change on a load strobe
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(perAct) && $stable(dutyAct)));
  // R9: count frozen when neither stepping nor clearing
  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.inc && !strb.clr) |=> $stable(cnt));
  // R8: a disabled block sits at count zero on the next cycle
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> cnt == '0);
  // R4: at count zero with a nonzero duty the output is at the duty level
  p_start_level_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && cnt == '0 && dutyAct != '0) |-> pwmOut == strb.pol);
endmodule

// File: rtl/pwm10_polsel.sv
module pwm10_polsel
  import pwm10_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int LOW_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          wrSel,
  input  logic [LOW_BITS-1:0] wrData,
  input  logic                tick,
  output logic                pwmOut
);
  pwmStrobe_t          strb;
  logic [RES_BITS-1:0] perStg, dutyStg;
  logic                atTop;

  pwm10_ctrl #(.RES_BITS(RES_BITS), .LOW_BITS(LOW_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .tick(tick), .atTop(atTop), .strb(strb), .perStg(perStg), .dutyStg(dutyStg)
  );

  pwm10_datapath #(.RES_BITS(RES_BITS)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .perStg(perStg), .dutyStg(dutyStg),
    .atTop(atTop), .pwmOut(pwmOut)
  );

  // R8: while disabled the output rests opposite to polarity
  p_idle_level_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |-> pwmOut != strb.pol);
endmodule

// File: tb/sim_pwm10_polsel.sv
module sim_pwm10_polsel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic tick = 1'b0;
  logic pwmOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pwm10_polsel u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .tick(tick), .pwmOut(pwmOut)
  );

  always #10 clk = ~clk;

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: pwmOut=%0b expected %0b at t=%0t", req, got, exp, $time);
    end
  endtask

  function automatic logic expOut(int k, int p, int d, logic pol);
    if (d >= p) return pol;                    // R6
    return ((k % (p + 1)) < d) ? pol : !pol;   // R3, R4, R5
  endfunction

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // upper nibble of the shared high register carries junk (R2)
  task automatic loadValues(input int p, input int d);
    writeReg(2'd0, p[7:0]);
    writeReg(2'd1, d[7:0]);
    writeReg(2'd2, {4'b1010, p[9:8], d[9:8]});
  endtask

  task automatic runTicks(input int n, input int startK, input int p,
                          input int d, input logic pol, input string req);
    for (int i = 0; i < n; i++) begin
      check(pwmOut, expOut(startK + i, p, d, pol), req);
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  initial begin
    int pl[6];
    int dl[5];
    pl = '{0, 1, 3, 7, 300, 1023};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(pwmOut, 1'b1, "R1 reset idle level");

    // Sweep period, duty and polarity
    for (int pi = 0; pi < 6; pi++) begin
      for (int pv = 0; pv < 2; pv++) begin
        int p;
        logic pol;
        p = pl[pi];
        pol = logic'(pv);
        dl = '{0, 1, p / 2, p, (p < 1023) ? p + 1 : 1023};
        for (int di = 0; di < 5; di++) begin
          writeReg(2'd3, {6'd0, pol, 1'b0});
          loadValues(p, dl[di]);
          check(pwmOut, !pol, "R8 disabled idle level");
          writeReg(2'd3, {6'd0, pol, 1'b1});
          runTicks(2 * (p + 1), 0, p, dl[di], pol, "R2 R3 R4 R5 R6 sweep");
        end
      end
    end

    // Gapped ticks: count moves only on tick cycles (R9)
    writeReg(2'd3, 8'h02);
    loadValues(5, 3);
    writeReg(2'd3, 8'h03);
    for (int i = 0; i < 24; i++) begin
      check(pwmOut, expOut((i + 1) / 2, 5, 3, 1'b1), "R9 gapped ticks");
      tick = (i % 2 == 0);
      @(negedge clk);
    end
    tick = 1'b0;

    // Mid-cycle reprogram takes effect only at the wrap (R7)
    writeReg(2'd3, 8'h02);
    loadValues(9, 4);
    writeReg(2'd3, 8'h03);
    runTicks(6, 0, 9, 4, 1'b1, "R7 before reprogram");
    writeReg(2'd0, 8'd3);
    check(pwmOut, expOut(6, 9, 4, 1'b1), "R7 R9 hold during write");
    writeReg(2'd1, 8'd1);
    check(pwmOut, expOut(6, 9, 4, 1'b1), "R7 R9 hold during write");
    writeReg(2'd2, 8'hF0);
    check(pwmOut, expOut(6, 9, 4, 1'b1), "R7 R9 hold during write");
    runTicks(4, 6, 9, 4, 1'b1, "R7 old values finish cycle");
    runTicks(8, 0, 3, 1, 1'b1, "R7 new values after wrap");

    // Disable drops to idle level and restart begins at count 0 (R8)
    writeReg(2'd3, 8'h00);
    check(pwmOut, 1'b1, "R8 disabled polarity 0");
    writeReg(2'd3, 8'h01);
    runTicks(8, 0, 3, 1, 1'b0, "R8 restart from zero");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule